// File: doc/BRIEF.md
# Temperature Limit Comparator With Event

This block watches a stream of signed 12-bit temperature samples that arrive from a converter interface, one sample per `sampleValid` strobe, where one LSB stands for 0.0625 °C. Each new sample is checked against three programmable limits: a high limit, a low limit and a critical limit. The outcome is held in a three-bit status word that records which limits the latest sample violated.

The status word drives a single shared event pin. In its default style the pin behaves like an open-drain, active-low line. The block either pulls it low, shown as output enable high with constant-zero data, or releases it. A polarity control turns the pin into a push-pull, active-high output instead. An enable control can hold the pin released while the status word keeps tracking new samples.

Limits and controls are written through a small synchronous register port. Every register, the status word included, can be read back combinationally. Conversions arrive at least ten times per second, so the status never lags the sensor by more than one conversion interval.

Top module: `temp_limit_monitor`

## Requirements
- R1: After reset all three limits read zero, the control register reads zero (event disabled, open-drain polarity), the status register reads zero, and `evtOe` and `evtOut` are both low.
- R2: A write with `regWrEn` high is stored at the next rising clock edge. Address 0 is control, with bit 0 as event enable and bit 1 as polarity. Address 1 is the high limit, address 2 the low limit and address 3 the critical limit. Each reads back the value written. Addresses 5 to 7 read zero.
- R3: Status bit 0 (above-high) takes the value sample > high limit at the rising edge where `sampleValid` is high.
- R4: Status bit 1 (below-low) takes the value sample < low limit at the rising edge where `sampleValid` is high.
- R5: Status bit 2 (above-critical) takes the value sample > critical limit at the rising edge where `sampleValid` is high.
- R6: Samples and limits are 12-bit two's complement, and every comparison is signed. For example, 0x800 (-2048) lies below a low limit of 0x050.
- R7: The status register changes only on a `sampleValid` edge. A limit write alone leaves the status unchanged until the next sample.
- R8: The status register at address 4 is read-only. A write to it changes nothing.
- R9: With enable set and polarity clear, `evtOut` stays 0 and `evtOe` is 1 exactly when any status bit is set.
- R10: With enable set and polarity set, `evtOe` is 1 and `evtOut` equals the OR of the status bits.
- R11: With enable clear, `evtOe` and `evtOut` are both 0 whatever the status, and the status still updates on new samples.
- R12: A sample equal to a limit does not violate that limit, because all three comparisons are strict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Strobe marking a new conversion result |
| sampleData | input | 12 | Signed temperature sample, 0.0625 °C per LSB |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for both write and read |
| regWrData | input | 12 | Register write data |
| regRdData | output | 12 | Combinational read data for `regAddr` |
| evtOe | output | 1 | Event pin drive enable (pull low in open-drain style) |
| evtOut | output | 1 | Event pin data, constant 0 in open-drain style |

## Verification
The hardest case to reach from the ports is a status word that must not move even though its inputs did. This happens when a limit is rewritten so that the held sample would now compare differently, and when software writes to the status address itself. The stimulus first lands a sample that sets above-high. It then raises the high limit past that sample and writes ones to the status address. It reads the status and the event pin back over several idle cycles before the next sample arrives. A second hard case is a sample that arrives while the event is disabled; its status change is observed through the read port while the pin stays released.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int NUM_LIM   = 3;
  localparam int LIM_HIGH  = 0;
  localparam int LIM_LOW   = 1;
  localparam int LIM_CRIT  = 2;

  localparam int ADDR_W    = 3;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_LIM0 = 1;  // limits sit at ADDR_LIM0 + index
  localparam int ADDR_STAT = 4;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_POL  = 1;

  typedef struct packed {
    logic               ctrlLoad;
    logic [NUM_LIM-1:0] limLoad;
    logic               capture;
  } strobe_t;
endpackage

// File: rtl/tlm_control.sv
module tlm_control
  import tlm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleValid,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [1:0]         ctrlWrBits,
  input  logic [NUM_LIM-1:0] statusBits,
  output strobe_t            strobes,
  output logic               ctrlEnable,
  output logic               ctrlPol,
  output logic               evtOe,
  output logic               evtOut
);
  logic eventActive;

  always_comb begin
    strobes.ctrlLoad = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
    strobes.capture  = sampleValid;
  end

  for (genvar i = 0; i < NUM_LIM; i++) begin : g_limDec
    assign strobes.limLoad[i] = regWrEn && (regAddr == ADDR_W'(ADDR_LIM0 + i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlEnable <= 1'b0;
      ctrlPol    <= 1'b0;
    end else if (strobes.ctrlLoad) begin
      ctrlEnable <= ctrlWrBits[CTRL_EN];
      ctrlPol    <= ctrlWrBits[CTRL_POL];
    end
  end

  // Open-drain style: enable pulls low, data stays zero.
  // Push-pull style: always driven, data carries the event active high.
  always_comb begin
    eventActive = |statusBits;
    evtOe       = ctrlEnable && (ctrlPol || eventActive);
    evtOut      = ctrlEnable && ctrlPol && eventActive;
  end
endmodule

// File: rtl/tlm_datapath.sv
module tlm_datapath
  import tlm_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  strobe_t                      strobes,
  input  logic [SAMPLE_W-1:0]          regWrData,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [SAMPLE_W-1:0]          sampleData,
  input  logic                         ctrlEnable,
  input  logic                         ctrlPol,
  output logic [NUM_LIM-1:0]           statusBits,
  output logic [NUM_LIM*SAMPLE_W-1:0]  limFlat,
  output logic [SAMPLE_W-1:0]          regRdData
);
  logic signed [SAMPLE_W-1:0] limQ [NUM_LIM];
  logic [NUM_LIM-1:0]         violate;
  logic signed [SAMPLE_W-1:0] sampleS;

  assign sampleS = $signed(sampleData);

  for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 limQ[i] <= '0;
      else if (strobes.limLoad[i]) limQ[i] <= $signed(regWrData);
    end

    if (i == LIM_LOW) begin : g_under
      assign violate[i] = sampleS < limQ[i];
    end else begin : g_over
      assign violate[i] = sampleS > limQ[i];
    end

    assign limFlat[i*SAMPLE_W +: SAMPLE_W] = limQ[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               statusBits <= '0;
    else if (strobes.capture) statusBits <= violate;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_CTRL): begin
        regRdData[CTRL_EN]  = ctrlEnable;
        regRdData[CTRL_POL] = ctrlPol;
      end
      ADDR_W'(ADDR_LIM0 + LIM_HIGH): regRdData = limQ[LIM_HIGH];
      ADDR_W'(ADDR_LIM0 + LIM_LOW):  regRdData = limQ[LIM_LOW];
      ADDR_W'(ADDR_LIM0 + LIM_CRIT): regRdData = limQ[LIM_CRIT];
      ADDR_W'(ADDR_STAT):            regRdData[NUM_LIM-1:0] = statusBits;
      default:                       regRdData = '0;
    endcase
  end
endmodule

// File: rtl/temp_limit_monitor.sv
module temp_limit_monitor
  import tlm_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [SAMPLE_W-1:0] regWrData,
  output logic [SAMPLE_W-1:0] regRdData,
  output logic                evtOe,
  output logic                evtOut
);
  strobe_t                    strobes;
  logic                       ctrlEnable;
  logic                       ctrlPol;
  logic [NUM_LIM-1:0]         statusBits;
  logic [NUM_LIM*SAMPLE_W-1:0] limFlat;

  tlm_control u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sampleValid (sampleValid),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .ctrlWrBits  (regWrData[1:0]),
    .statusBits  (statusBits),
    .strobes     (strobes),
    .ctrlEnable  (ctrlEnable),
    .ctrlPol     (ctrlPol),
    .evtOe       (evtOe),
    .evtOut      (evtOut)
  );

  tlm_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .regWrData  (regWrData),
    .regAddr    (regAddr),
    .sampleData (sampleData),
    .ctrlEnable (ctrlEnable),
    .ctrlPol    (ctrlPol),
    .statusBits (statusBits),
    .limFlat    (limFlat),
    .regRdData  (regRdData)
  );
endmodule

// File: rtl/tlm_checker.sv
module tlm_checker
  import tlm_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sampleValid,
  input logic [SAMPLE_W-1:0]         sampleData,
  input logic [NUM_LIM*SAMPLE_W-1:0] limFlat,
  input logic [NUM_LIM-1:0]          statusBits,
  input logic                        ctrlEnable,
  input logic                        ctrlPol,
  input logic                        evtOe,
  input logic                        evtOut
);
  logic signed [SAMPLE_W-1:0] sHigh, sLow, sCrit, sSmp;
  assign sHigh = $signed(limFlat[LIM_HIGH*SAMPLE_W +: SAMPLE_W]);
  assign sLow  = $signed(limFlat[LIM_LOW*SAMPLE_W  +: SAMPLE_W]);
  assign sCrit = $signed(limFlat[LIM_CRIT*SAMPLE_W +: SAMPLE_W]);
  assign sSmp  = $signed(sampleData);

  p_above_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> statusBits[LIM_HIGH] == ($past(sSmp) > $past(sHigh)));

  p_below_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> statusBits[LIM_LOW] == ($past(sSmp) < $past(sLow)));

  p_above_crit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> statusBits[LIM_CRIT] == ($past(sSmp) > $past(sCrit)));

  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> $stable(statusBits));

  p_open_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlEnable && !ctrlPol) |-> (!evtOut && (evtOe == (statusBits != '0))));

  p_push_pull_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlEnable && ctrlPol) |-> (evtOe && (evtOut == (statusBits != '0))));

  p_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlEnable |-> (!evtOe && !evtOut));
endmodule

bind temp_limit_monitor tlm_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sampleValid (sampleValid),
  .sampleData  (sampleData),
  .limFlat     (limFlat),
  .statusBits  (statusBits),
  .ctrlEnable  (ctrlEnable),
  .ctrlPol     (ctrlPol),
  .evtOe       (evtOe),
  .evtOut      (evtOut)
);

// File: tb/temp_limit_monitor_tb.sv
module temp_limit_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // Row layout: {high, low, crit, sample, expected status {crit, low, high}}
  localparam logic [50:0] VEC [NVEC] = '{
    {12'h190, 12'h050, 12'h320, 12'h100, 3'b000},  // inside window
    {12'h190, 12'h050, 12'h320, 12'h1A0, 3'b001},  // R3 above high
    {12'h190, 12'h050, 12'h320, 12'h040, 3'b010},  // R4 below low
    {12'h190, 12'h050, 12'h320, 12'h400, 3'b101},  // R5 above critical
    {12'h190, 12'h050, 12'h320, 12'hFF0, 3'b010},  // R6 negative sample
    {12'h190, 12'h050, 12'h320, 12'h800, 3'b010},  // R6 most negative
    {12'h190, 12'h050, 12'h320, 12'h7FF, 3'b101},  // R6 most positive
    {12'h190, 12'h050, 12'h320, 12'h190, 3'b000},  // R12 equal high
    {12'h190, 12'h050, 12'h320, 12'h050, 3'b000},  // R12 equal low
    {12'h190, 12'h050, 12'h320, 12'h320, 3'b001},  // R12 equal critical
    {12'hF80, 12'hF00, 12'h000, 12'hF40, 3'b000},  // R6 negative limits
    {12'hF80, 12'hF00, 12'h000, 12'hFC0, 3'b001},
    {12'hF80, 12'hF00, 12'h000, 12'hE00, 3'b010},
    {12'hF80, 12'hF00, 12'h000, 12'h010, 3'b101}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [11:0] regWrData = '0;
  logic [11:0] regRdData;
  logic        evtOe, evtOut;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_limit_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleData(sampleData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .evtOe(evtOe), .evtOut(evtOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [11:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pushSample(input logic [11:0] s);
    @(negedge clk);
    sampleValid = 1'b1; sampleData = s;
    @(negedge clk);
    sampleValid = 1'b0;
    #1;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [11:0] rd;
    logic [50:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      readReg(3'(a), rd);
      check("R1 reset register", 32'(rd), 32'h0);
    end
    check("R1 reset evtOe", 32'(evtOe), 32'h0);
    check("R1 reset evtOut", 32'(evtOut), 32'h0);

    // R2 register map
    writeReg(3'd0, 12'h003);
    readReg(3'd0, rd); check("R2 ctrl readback", 32'(rd), 32'h3);
    writeReg(3'd1, 12'hABC);
    readReg(3'd1, rd); check("R2 high readback", 32'(rd), 32'hABC);
    writeReg(3'd2, 12'h123);
    readReg(3'd2, rd); check("R2 low readback", 32'(rd), 32'h123);
    writeReg(3'd3, 12'h7F0);
    readReg(3'd3, rd); check("R2 crit readback", 32'(rd), 32'h7F0);
    writeReg(3'd5, 12'hFFF);
    readReg(3'd5, rd); check("R2 unused address", 32'(rd), 32'h0);
    readReg(3'd7, rd); check("R2 unused address 7", 32'(rd), 32'h0);

    // Table: R3 R4 R5 R6 R12 and open-drain event R9
    writeReg(3'd0, 12'h001);
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      writeReg(3'd1, v[50:39]);
      writeReg(3'd2, v[38:27]);
      writeReg(3'd3, v[26:15]);
      pushSample(v[14:3]);
      readReg(3'd4, rd);
      check($sformatf("R3/R4/R5 status row %0d", i), 32'(rd), 32'(v[2:0]));
      check($sformatf("R9 evtOe row %0d", i), 32'(evtOe), 32'(v[2:0] != 3'b000));
      check($sformatf("R9 evtOut row %0d", i), 32'(evtOut), 32'h0);
    end

    // R7 / R8: status held across limit writes, status writes and idle cycles
    writeReg(3'd1, 12'h190);
    writeReg(3'd2, 12'h050);
    writeReg(3'd3, 12'h320);
    pushSample(12'h1A0);
    readReg(3'd4, rd); check("R7 setup status", 32'(rd), 32'h1);
    writeReg(3'd1, 12'h7FF);
    readReg(3'd4, rd); check("R7 status after limit write", 32'(rd), 32'h1);
    check("R7 event after limit write", 32'(evtOe), 32'h1);
    writeReg(3'd4, 12'h006);
    readReg(3'd4, rd); check("R8 status write ignored", 32'(rd), 32'h1);
    writeReg(3'd4, 12'h000);
    repeat (4) @(negedge clk);
    readReg(3'd4, rd); check("R7 status held idle", 32'(rd), 32'h1);
    pushSample(12'h1A0);
    readReg(3'd4, rd); check("R7 new sample uses new limit", 32'(rd), 32'h0);

    // R10 push-pull polarity
    writeReg(3'd1, 12'h190);
    writeReg(3'd0, 12'h003);
    #1;
    check("R10 idle evtOe", 32'(evtOe), 32'h1);
    check("R10 idle evtOut", 32'(evtOut), 32'h0);
    pushSample(12'h040);
    check("R10 event evtOe", 32'(evtOe), 32'h1);
    check("R10 event evtOut", 32'(evtOut), 32'h1);

    // R11 disabled: pin released, status still moves
    writeReg(3'd0, 12'h002);
    #1;
    check("R11 disabled evtOe", 32'(evtOe), 32'h0);
    check("R11 disabled evtOut", 32'(evtOut), 32'h0);
    pushSample(12'h400);
    readReg(3'd4, rd); check("R11 status updates while disabled", 32'(rd), 32'h5);
    check("R11 disabled evtOe after sample", 32'(evtOe), 32'h0);
    check("R11 disabled evtOut after sample", 32'(evtOut), 32'h0);

    // R1 reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    readReg(3'd1, rd); check("R1 reset clears limit", 32'(rd), 32'h0);
    readReg(3'd4, rd); check("R1 reset clears status", 32'(rd), 32'h0);
    readReg(3'd0, rd); check("R1 reset clears ctrl", 32'(rd), 32'h0);

    finishRun();
  end
endmodule